// File: doc/BRIEF.md
# Protection Counter Bank-Switch Controller

This block sits on the cartridge side of an 8-bit CPU bus and decides which 32 KiB program ROM bank and which 8 KiB character ROM bank are visible. Software cannot write a bank number directly. It first stages a 3-bit value and a single status bit through a small protection unit in the `$4100` area. It then moves that value into a working register, which can load it as written, load its bitwise inverse, or count it up by one. Any write into the upper 32 KiB commits the working register to the bank lines, whatever the data. The working register and the status bit (after the invert flag is applied) can be read back, and software can use this as a copy-protection check.

A single bus sequencer watches the CPU cycle strobe. State `ST_IDLE` takes a new cycle. It moves to `ST_WR_HELD` when the cycle is a write and to `ST_RD_HELD` when it is a read. Both held states return to `ST_IDLE` when the strobe drops. The register or bank update fires only on the `ST_IDLE` to held transition, so it happens exactly once per bus cycle, however long the cycle lasts. The readback drive is combinational for the whole length of a matching read cycle.

Top module: `prot_bank_ctrl`

## Requirements
- R1: A write whose address ANDed with `$E103` equals `$4102` loads data bit 3 into status bit S and data bits 2..0 into stage register P. Mirrors such as `$5F02` also hit. An address that misses every register decode and has bit 15 clear (for example `$6000`) changes nothing.
- R2: A write decoding to `$4101` loads data bit 0 into invert flag V. A write decoding to `$4103` loads data bit 0 into step flag C.
- R3: A write decoding to `$4100` while C=1 adds one to the 3-bit working register R, modulo 8 (7 becomes 0).
- R4: A write decoding to `$4100` while C=0 loads R with P when V=0, and with the bitwise inverse of P when V=1.
- R5: A write to `$4100` never alters S, and its data value has no effect.
- R6: During a read cycle whose address ANDed with `$E100` equals `$4100`, `bus_rdata[3]` is S XOR V, `bus_rdata[2:0]` is R, `bus_rd_oe` is `8'h0F`, and bits 7..4 are never driven.
- R7: A new S is visible on the next readback. A new P is not visible until a `$4100` write has moved it into R.
- R8: Any write with address bit 15 set copies R into the bank latch and ignores the data. `prg_bank` is latch bit 2, and `chr_bank` is latch bits 1..0. Nothing else changes the bank lines.
- R9: A bus cycle held for many clocks applies its register effect exactly once.
- R10: Reset clears P, R, S, V, C and the bank latch, so the bank lines are 0 and a readback gives `4'h0`.
- R11: `bus_rd_oe` is zero outside a read cycle that matches the read decode (for example during writes, or when reading `$4000`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, faster than the CPU bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | High for the duration of one CPU bus cycle |
| bus_rnw | input | 1 | 1 for a read cycle, 0 for a write cycle |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Readback value; only bits 3..0 carry information |
| bus_rd_oe | output | 8 | Per-bit drive enable for `bus_rdata` |
| prg_bank | output | 1 | Program ROM bank line (selects a 32 KiB half) |
| chr_bank | output | 2 | Character ROM bank lines (select one of four 8 KiB banks) |

## Verification
The assertions assume that `bus_addr`, `bus_rnw` and `bus_wdata` are stable while `bus_cyc` is high, and that `bus_cyc` drops for at least one clock between cycles. If either assumption breaks, the single-update-per-cycle properties lose their meaning. The bench drives every input at the falling clock edge and holds each cycle for a fixed span of clocks, including one very long write, with one idle clock after each cycle. It never changes address or direction in the middle of a cycle.

// File: rtl/prot_bank_pkg.sv
package prot_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HELD = 2'd1,
        ST_RD_HELD = 2'd2
    } bus_state_t;

    localparam int unsigned NUM_REGS = 4;

    // Register index is the low two address bits of the protection window.
    localparam int unsigned RG_COMMIT = 0;
    localparam int unsigned RG_INVERT = 1;
    localparam int unsigned RG_STAGE  = 2;
    localparam int unsigned RG_STEP   = 3;

    localparam logic [15:0] WR_MASK  = 16'hE103;
    localparam logic [15:0] RD_MASK  = 16'hE100;
    localparam logic [15:0] REG_BASE = 16'h4100;

endpackage

// File: rtl/prot_bus_seq.sv
module prot_bus_seq
    import prot_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cyc,
    input  logic                bus_rnw,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_REGS-1:0] reg_we,
    output logic                rom_we,
    output logic                rd_hit
);

    localparam logic [ADDR_W-1:0] WMASK = ADDR_W'(WR_MASK);
    localparam logic [ADDR_W-1:0] RMASK = ADDR_W'(RD_MASK);
    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(REG_BASE);

    bus_state_t state_q, state_d;
    logic [NUM_REGS-1:0] reg_hit;
    logic                wr_start;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign reg_hit[g] = (bus_addr & WMASK) == (BASE | ADDR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_cyc) state_d = bus_rnw ? ST_RD_HELD : ST_WR_HELD;
            end
            ST_WR_HELD, ST_RD_HELD: begin
                if (!bus_cyc) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_start = 1'b0;
        unique case (state_q)
            ST_IDLE:    wr_start = bus_cyc && !bus_rnw;
            ST_WR_HELD: wr_start = 1'b0;
            ST_RD_HELD: wr_start = 1'b0;
            default:    wr_start = 1'b0;
        endcase
        rom_we = wr_start && bus_addr[ADDR_W-1];
        reg_we = wr_start ? reg_hit : '0;
        rd_hit = bus_cyc && bus_rnw && ((bus_addr & RMASK) == BASE);
    end

endmodule

// File: rtl/prot_core.sv
module prot_core
    import prot_bank_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] reg_we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [CNT_W-1:0]    work_r,
    output logic                stage_s,
    output logic                inv_flag,
    output logic                inc_flag
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] stage_p;
    logic [CNT_W-1:0] work_d;

    always_comb begin
        if (inc_flag)      work_d = work_r + ONE;
        else if (inv_flag) work_d = ~stage_p;
        else               work_d = stage_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_p  <= '0;
            stage_s  <= 1'b0;
            inv_flag <= 1'b0;
            inc_flag <= 1'b0;
            work_r   <= '0;
        end else begin
            if (reg_we[RG_STAGE]) begin
                stage_p <= wdata[CNT_W-1:0];
                stage_s <= wdata[CNT_W];
            end
            if (reg_we[RG_INVERT]) inv_flag <= wdata[0];
            if (reg_we[RG_STEP])   inc_flag <= wdata[0];
            if (reg_we[RG_COMMIT]) work_r   <= work_d;
        end
    end

endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] d,
    output logic             prg_bank,
    output logic [CNT_W-2:0] chr_bank
);

    logic [CNT_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    assign prg_bank = q[CNT_W-1];
    assign chr_bank = q[CNT_W-2:0];

endmodule

// File: rtl/prot_bank_ctrl.sv
module prot_bank_ctrl
    import prot_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cyc,
    input  logic              bus_rnw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_rd_oe,
    output logic              prg_bank,
    output logic [CNT_W-2:0]  chr_bank
);

    localparam int unsigned RB_W  = CNT_W + 1;
    localparam int unsigned PAD_W = DATA_W - RB_W;

    logic [NUM_REGS-1:0] reg_we;
    logic                rom_we;
    logic                rd_hit;
    logic [CNT_W-1:0]    work_r;
    logic                stage_s;
    logic                inv_flag;
    logic                inc_flag;
    logic [RB_W-1:0]     readback;

    prot_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cyc  (bus_cyc),
        .bus_rnw  (bus_rnw),
        .bus_addr (bus_addr),
        .reg_we   (reg_we),
        .rom_we   (rom_we),
        .rd_hit   (rd_hit)
    );

    prot_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .wdata    (bus_wdata),
        .work_r   (work_r),
        .stage_s  (stage_s),
        .inv_flag (inv_flag),
        .inc_flag (inc_flag)
    );

    bank_latch #(.CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rom_we),
        .d        (work_r),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank)
    );

    assign readback  = {stage_s ^ inv_flag, work_r};
    assign bus_rdata = {{PAD_W{1'b0}}, readback};
    assign bus_rd_oe = rd_hit ? {{PAD_W{1'b0}}, {RB_W{1'b1}}} : '0;

endmodule

// File: rtl/prot_bank_ctrl_chk.sv
module prot_bank_ctrl_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cyc,
    input logic              bus_rnw,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rd_oe,
    input logic              prg_bank,
    input logic [CNT_W-2:0]  chr_bank,
    input logic [CNT_W-1:0]  work_r,
    input logic              stage_s,
    input logic              inc_flag
);

    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);
    localparam logic [ADDR_W-1:0] CMASK  = ADDR_W'(16'hE103);
    localparam logic [ADDR_W-1:0] CMATCH = ADDR_W'(16'h4100);

    logic prev_cyc;
    logic start_wr;
    logic commit_wr;
    logic rom_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_cyc <= 1'b0;
        else        prev_cyc <= bus_cyc;
    end

    assign start_wr  = bus_cyc && !prev_cyc && !bus_rnw;
    assign commit_wr = start_wr && ((bus_addr & CMASK) == CMATCH);
    assign rom_wr    = start_wr && bus_addr[ADDR_W-1];

    AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr && inc_flag) |=> (work_r == $past(work_r) + ONE)); // R3

    AST_S_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> $stable(stage_s)); // R5

    AST_BANK_TAKES_R: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wr |=> ({prg_bank, chr_bank} == $past(work_r))); // R8

    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_wr |=> $stable({prg_bank, chr_bank})); // R8

    AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && prev_cyc) |=> $stable(work_r)); // R9

    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_oe != '0) |-> (bus_cyc && bus_rnw)); // R11

    AST_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_oe[DATA_W-1:CNT_W+1] == '0); // R6

endmodule

bind prot_bank_ctrl prot_bank_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cyc   (bus_cyc),
    .bus_rnw   (bus_rnw),
    .bus_addr  (bus_addr),
    .bus_rd_oe (bus_rd_oe),
    .prg_bank  (prg_bank),
    .chr_bank  (chr_bank),
    .work_r    (work_r),
    .stage_s   (stage_s),
    .inc_flag  (inc_flag)
);

// File: tb/tb_prot_bank_ctrl.sv
module tb_prot_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cyc = 1'b0;
    logic        bus_rnw = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  bus_rd_oe;
    logic        prg_bank;
    logic [1:0]  chr_bank;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prot_bank_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cyc   (bus_cyc),
        .bus_rnw   (bus_rnw),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rd_oe (bus_rd_oe),
        .prg_bank  (prg_bank),
        .chr_bank  (chr_bank)
    );

    // Behavioural reference model
    int m_p, m_r, m_s, m_v, m_c, m_bank;
    bit m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p = 0; m_r = 0; m_s = 0; m_v = 0; m_c = 0; m_bank = 0; m_prev = 0;
        end else begin
            if (bus_cyc && !m_prev && !bus_rnw) begin
                if (bus_addr >= 16'h8000) m_bank = m_r;
                else if ((bus_addr & 16'hE103) == 16'h4102) begin
                    m_s = (bus_wdata >> 3) & 1;
                    m_p = bus_wdata & 7;
                end else if ((bus_addr & 16'hE103) == 16'h4101) m_v = bus_wdata & 1;
                else if ((bus_addr & 16'hE103) == 16'h4103) m_c = bus_wdata & 1;
                else if ((bus_addr & 16'hE103) == 16'h4100) begin
                    if (m_c != 0)      m_r = (m_r + 1) % 8;
                    else if (m_v != 0) m_r = 7 - m_p;
                    else               m_r = m_p;
                end
            end
            m_prev = bus_cyc;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare with the model on every clock
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit rd_match;
            rd_match = bus_cyc && bus_rnw && ((bus_addr & 16'hE100) == 16'h4100);
            chk("R8 bank lines vs model", int'({prg_bank, chr_bank}), m_bank);
            chk("R11 read enable vs model", int'(bus_rd_oe), rd_match ? 8'h0F : 8'h00);
            if (rd_match)
                chk("R6 readback vs model", int'(bus_rdata[3:0]), ((m_s ^ m_v) << 3) | m_r);
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        bus_cyc = 1'b1; bus_rnw = 1'b0; bus_addr = a; bus_wdata = d;
        repeat (hold) @(negedge clk);
        bus_cyc = 1'b0; bus_rnw = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] a, input string tag, input int exp_nib, input int exp_oe);
        @(negedge clk);
        bus_cyc = 1'b1; bus_rnw = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        chk({tag, " oe"}, int'(bus_rd_oe), exp_oe);
        if (exp_oe != 0) chk({tag, " data"}, int'(bus_rdata[3:0]), exp_nib);
        @(negedge clk);
        bus_cyc = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_bank(input string tag, input int exp);
        chk(tag, int'({prg_bank, chr_bank}), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_bank("R10 bank after reset", 0);
        bus_read(16'h4100, "R10 readback after reset", 4'h0, 8'h0F);

        bus_write(16'h4102, 8'h0D, 2);              // S=1 P=5
        bus_read(16'h4100, "R7 S shows, P hidden", 4'h8, 8'h0F);
        bus_write(16'h4100, 8'hFF, 2);              // R=P=5
        bus_read(16'h4100, "R4 load P, R5 S kept", 4'hD, 8'h0F);

        bus_write(16'h4101, 8'h01, 2);              // V=1
        bus_read(16'h4100, "R2 invert flag flips bit3", 4'h5, 8'h0F);
        bus_write(16'h4100, 8'h00, 2);              // R=~5=2
        bus_read(16'h4100, "R4 inverted load", 4'h2, 8'h0F);

        chk_bank("R8 bank untouched before ROM write", 0);
        bus_write(16'h8000, 8'h00, 2);
        chk_bank("R8 ROM write commits R=2", 2);

        bus_write(16'h4103, 8'h01, 2);              // C=1
        for (int i = 0; i < 5; i++) bus_write(16'h4100, 8'h00, 2);
        bus_read(16'h4100, "R3 step to 7", 4'h7, 8'h0F);
        bus_write(16'h4100, 8'h5A, 2);
        bus_read(16'h4100, "R3 wrap 7 to 0", 4'h0, 8'h0F);

        bus_write(16'h4100, 8'h00, 12);             // long cycle, one step
        bus_read(16'h4100, "R9 single step per cycle", 4'h1, 8'h0F);

        bus_write(16'h5F02, 8'h03, 2);              // mirror: S=0 P=3
        bus_read(16'h41FF, "R1 mirror stage, R6 mirror read", 4'h9, 8'h0F);

        bus_write(16'h6000, 8'h0F, 2);              // no decode
        bus_read(16'h4100, "R1 unmatched write ignored", 4'h9, 8'h0F);
        bus_read(16'h4000, "R11 no drive outside decode", 0, 8'h00);
        chk_bank("R1 bank unchanged by unmatched write", 2);

        bus_write(16'h4103, 8'hFE, 2);              // C=0 (bit0 only)
        bus_write(16'h4101, 8'hF0, 2);              // V=0
        bus_write(16'h4100, 8'h00, 2);              // R=3
        bus_read(16'h4100, "R2 flags from bit0 only", 4'h3, 8'h0F);
        bus_write(16'hFFFF, 8'hAA, 2);
        chk_bank("R8 data ignored, chr=3", 3);
        bus_write(16'h4103, 8'h01, 2);
        bus_write(16'h4100, 8'h00, 2);              // R=4
        bus_write(16'hC000, 8'h00, 2);
        chk_bank("R8 prg line from bit2", 4);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_bank("R10 bank cleared by reset", 0);
        rst_n = 1'b1;
        bus_read(16'h4100, "R10 readback cleared", 4'h0, 8'h0F);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule